// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a small synchronous static RAM that can take a new read or write on every clock edge. It never needs a dead cycle between a read and a following write. Address and control are registered at the edge where they are presented. Write data follows later on its own bus, with the same delay that read data shows in the selected output mode. Because of this alignment, the data slots of reads and writes never collide. Per-byte write enables mask which lanes of a word are changed.

A static mode input selects how the output is timed. In pipelined mode, read data passes through an extra output register. In flow-through mode, that register is bypassed and the latency is one edge shorter. A sleep input parks the core without losing its contents. Requests issued while the core is asleep, or still waking up, are dropped. The read-data outputs then stay in their released (zero, not valid) state.

Top module: `nobubble_sram`

## Requirements
- R1: A request (en=1) may be given on every edge, in any mix of reads (wr=0) and writes (wr=1), including long runs of only reads or only writes. Every accepted request is performed, with no idle cycle in between.
- R2: For a read accepted at edge e, rd_valid is high with the read word on rdata for exactly the one cycle after edge e+2 when pipe_sel=1 (pipelined), or after edge e+1 when pipe_sel=0 (flow-through).
- R3: For a write accepted at edge e, the data is sampled from wdata at edge e+2 in pipelined mode and at edge e+1 in flow-through mode.
- R4: byte_wr bit i set to 1 updates bits [8i+7:8i] of the addressed word. Lanes whose bit is 0 keep their previous contents.
- R5: A read returns the effect of every write accepted at an earlier edge, even when that write's data is sampled at the same edge the read looks at the array.
- R6: If sleep_req is high at edge k, requests at edges k and k+1 are still accepted. Requests at edge k+2 and later are dropped while sleep_req stays high.
- R7: If sleep_req is low at edge m after a sleep, requests at edges m and m+1 are still dropped. Requests from edge m+2 on are accepted.
- R8: A dropped request writes nothing and never raises rd_valid.
- R9: Array contents are unchanged across a sleep period.
- R10: rdata is all zeros whenever rd_valid is low.
- R11: A synchronous reset (rst=1) clears rd_valid, pending requests and the sleep state. It leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pipe_sel | input | 1 | Output mode, static: 1 pipelined, 0 flow-through |
| sleep_req | input | 1 | Sleep request, 1 puts the core to sleep |
| en | input | 1 | Request strobe for this edge |
| wr | input | 1 | 1 write, 0 read |
| byte_wr | input | LANES | Per-lane write enables, bit i covers byte i |
| addr | input | ADDR_W | Word address |
| wdata | input | 8*LANES | Write data, sampled one or two edges after the request |
| rd_valid | output | 1 | Read data valid (output enable) |
| rdata | output | 8*LANES | Read data, zero when not valid |

## Verification
On every cycle, the assertions check three timing properties of reads. Each accepted read raises rd_valid after exactly the mode's latency. A raised rd_valid always traces back to an accepted read. A request made while asleep never produces valid data. The assertions also check that the sleep state follows the request two edges later, and that rdata is zero while invalid. Other behaviour is visible only in the bench's scenarios, where every word is compared with a behavioural memory model. This covers whether the data is correct, byte-lane masking, forwarding of late write data into the next read, dropped writes, and contents kept across a sleep or a reset.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    // width of one byte lane
    localparam int unsigned LANE_W = 8;
    // edges between a change of the sleep request and the core following it
    localparam int unsigned SLEEP_LAT = 2;

    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;
endpackage

// File: rtl/nbs_sleep_gate.sv
module nbs_sleep_gate
    import nbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic asleep
);
    // delay line: the core follows the request SLEEP_LAT edges later
    logic [SLEEP_LAT-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else begin
            dly_q <= {dly_q[SLEEP_LAT-2:0], sleep_req};
        end
    end

    assign asleep = dly_q[SLEEP_LAT-1];
endmodule

// File: rtl/nbs_array.sv
module nbs_array
    import nbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input  logic                      clk,
    input  logic                      wr_go,
    input  logic [LANES-1:0]          wr_lanes,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_word,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_word
);
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // lane-masked write port
    always_ff @(posedge clk) begin
        if (wr_go) begin
            for (int ln = 0; ln < int'(LANES); ln++) begin
                if (wr_lanes[ln]) begin
                    mem[wr_addr][ln*LANE_W +: LANE_W] <= wr_word[ln*LANE_W +: LANE_W];
                end
            end
        end
    end

    // asynchronous read; the caller registers the result
    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/nbs_fwd_merge.sv
module nbs_fwd_merge
    import nbs_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                    hit,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [LANES*LANE_W-1:0] stored,
    input  logic [LANES*LANE_W-1:0] incoming,
    output logic [LANES*LANE_W-1:0] merged
);
    // per lane: take the committing write's byte when it targets this word
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = (hit && lane_sel[g]) ?
                                            incoming[g*LANE_W +: LANE_W] :
                                            stored[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/nobubble_sram.sv
module nobubble_sram
    import nbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pipe_sel,
    input  logic                    sleep_req,
    input  logic                    en,
    input  logic                    wr,
    input  logic [LANES-1:0]        byte_wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    rd_valid,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int unsigned WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [LANES-1:0]  lanes;
        logic [ADDR_W-1:0] addr;
    } req_t;

    out_mode_e mode;
    logic      asleep;
    req_t      s1_q, s2_q, cm;
    logic      wr_go, rd_go, fwd_hit;
    logic [WORD_W-1:0] arr_word, fwd_word;
    logic              rd_v_q, out_v_q;
    logic [WORD_W-1:0] rd_q, out_q;

    assign mode = out_mode_e'(pipe_sel);

    nbs_sleep_gate u_sleep (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .asleep    (asleep)
    );

    // stage 1: request capture, gated by sleep (fields frozen when idle)
    // stage 2: request held one more edge for pipelined-mode write data
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q.vld <= en & ~asleep;
            if (en && !asleep) begin
                s1_q.wr    <= wr;
                s1_q.lanes <= byte_wr;
                s1_q.addr  <= addr;
            end
            s2_q <= s1_q;
        end
    end

    // commit stage: the write whose data is on wdata at this edge
    assign cm      = (mode == OUT_PIPE) ? s2_q : s1_q;
    assign wr_go   = cm.vld & cm.wr;
    assign rd_go   = s1_q.vld & ~s1_q.wr;
    assign fwd_hit = wr_go & rd_go & (cm.addr == s1_q.addr);

    nbs_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_array (
        .clk      (clk),
        .wr_go    (wr_go),
        .wr_lanes (cm.lanes),
        .wr_addr  (cm.addr),
        .wr_word  (wdata),
        .rd_addr  (s1_q.addr),
        .rd_word  (arr_word)
    );

    nbs_fwd_merge #(
        .LANES (LANES)
    ) u_merge (
        .hit      (fwd_hit),
        .lane_sel (cm.lanes),
        .stored   (arr_word),
        .incoming (wdata),
        .merged   (fwd_word)
    );

    // read register (flow-through output) and output register (pipelined)
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v_q  <= 1'b0;
            out_v_q <= 1'b0;
        end else begin
            rd_v_q  <= rd_go;
            out_v_q <= rd_v_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_go) begin
            rd_q <= fwd_word;
        end
        if (rd_v_q) begin
            out_q <= rd_q;
        end
    end

    always_comb begin
        if (mode == OUT_PIPE) begin
            rd_valid = out_v_q;
            rdata    = out_v_q ? out_q : '0;
        end else begin
            rd_valid = rd_v_q;
            rdata    = rd_v_q ? rd_q : '0;
        end
    end
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              pipe_sel,
    input logic              sleep_req,
    input logic              en,
    input logic              wr,
    input logic              asleep,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rdata
);
    // R2: accepted read shows up after the mode's latency
    p_flow_rd_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (!pipe_sel && en && !wr && !asleep) |-> ##2 rd_valid);
    p_pipe_rd_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && en && !wr && !asleep) |-> ##3 rd_valid);

    // R8: a raised valid always traces back to an accepted read
    p_flow_no_spur_r8: assert property (@(posedge clk) disable iff (rst)
        (!pipe_sel && rd_valid) |-> $past(en && !wr && !asleep, 2));
    p_pipe_no_spur_r8: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && rd_valid) |-> $past(en && !wr && !asleep, 3));

    // R8: requests while asleep never produce data
    p_flow_sleep_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (!pipe_sel && en && asleep) |-> ##2 !rd_valid);
    p_pipe_sleep_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && en && asleep) |-> ##3 !rd_valid);

    // R6 / R7: sleep state follows the request two edges later
    p_sleep_enter_r6: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> ##2 asleep);
    p_sleep_exit_r7: assert property (@(posedge clk) disable iff (rst)
        !sleep_req |-> ##2 !asleep);

    // R10: released bus reads as zero
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rdata == '0));
endmodule

bind nobubble_sram nbs_checker #(
    .DATA_W ($bits(wdata))
) u_nbs_checker (
    .clk       (clk),
    .rst       (rst),
    .pipe_sel  (pipe_sel),
    .sleep_req (sleep_req),
    .en        (en),
    .wr        (wr),
    .asleep    (asleep),
    .rd_valid  (rd_valid),
    .rdata     (rdata)
);

// File: tb/nobubble_sram_tb_top.sv
module nobubble_sram_tb_top;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pipe_sel = 1'b1;
    logic          sleep_req = 1'b0;
    logic          en = 1'b0;
    logic          wr = 1'b0;
    logic [NB-1:0] byte_wr = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rdata;

    always #5 clk = ~clk;

    nobubble_sram #(.ADDR_W(AW), .LANES(NB)) dut_i (
        .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .sleep_req(sleep_req),
        .en(en), .wr(wr), .byte_wr(byte_wr), .addr(addr), .wdata(wdata),
        .rd_valid(rd_valid), .rdata(rdata)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string tag      = "R11";
    int    nxt      = 1;

    // behavioural model state, slots indexed by edge number mod 8
    logic [DW-1:0] mmem [1<<AW];
    bit            exp_v [8];
    logic [DW-1:0] exp_d [8];
    bit            wp_v  [8];
    logic [AW-1:0] wp_a  [8];
    logic [NB-1:0] wp_b  [8];
    bit            rp_v  [8];
    logic [AW-1:0] rp_a  [8];
    logic [DW-1:0] wsched [8];
    bit            sl1 = 0, sl2 = 0;

    task automatic model_update(input int n);
        int lat = pipe_sel ? 2 : 1;
        int s = n % 8;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                exp_v[i] = 0; wp_v[i] = 0; rp_v[i] = 0;
            end
            sl1 = 0; sl2 = 0;
            return;
        end
        if (wp_v[s]) begin
            for (int ln = 0; ln < NB; ln++)
                if (wp_b[s][ln]) mmem[wp_a[s]][ln*8 +: 8] = wdata[ln*8 +: 8];
            wp_v[s] = 0;
        end
        if (rp_v[s]) begin
            exp_v[(n + lat - 1) % 8] = 1;
            exp_d[(n + lat - 1) % 8] = mmem[rp_a[s]];
            rp_v[s] = 0;
        end
        if (en && !sl2) begin
            if (wr) begin
                wp_v[(n + lat) % 8] = 1;
                wp_a[(n + lat) % 8] = addr;
                wp_b[(n + lat) % 8] = byte_wr;
            end else begin
                rp_v[(n + 1) % 8] = 1;
                rp_a[(n + 1) % 8] = addr;
            end
        end
        sl2 = sl1;
        sl1 = sleep_req;
    endtask

    task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s edge %0d %s: actual=%h expected=%h", tag, nxt, what, act, exp);
        end
    endtask

    task automatic compare(input int n);
        int s = n % 8;
        check(rd_valid === exp_v[s], "rd_valid", DW'(rd_valid), DW'(exp_v[s]));
        if (exp_v[s]) check(rdata === exp_d[s], "rdata", rdata, exp_d[s]);
        else          check(rdata === '0, "rdata idle (R10)", rdata, '0);
        exp_v[s] = 0;
    endtask

    task automatic tick(input bit e, input bit w, input logic [NB-1:0] b,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat = pipe_sel ? 2 : 1;
        en = e; wr = w; byte_wr = b; addr = a;
        if (e && w) wsched[(nxt + lat) % 8] = d;
        wdata = wsched[nxt % 8];
        wsched[nxt % 8] = $urandom();
        @(posedge clk);
        model_update(nxt);
        @(negedge clk);
        compare(nxt);
        nxt++;
    endtask

    task automatic rand_op(input int span);
        tick(($urandom % 8) != 0, $urandom % 2, NB'($urandom), AW'($urandom % span), $urandom());
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) tick(0, 0, '0, '0, '0);
    endtask

    task automatic do_reset(input bit mode);
        rst = 1; en = 0; sleep_req = 0;
        @(negedge clk);
        pipe_sel = mode;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); model_update(nxt); @(negedge clk); compare(nxt); nxt++;
        end
        rst = 0;
    endtask

    task automatic readback();
        for (int a = 0; a < (1 << AW); a++) tick(1, 0, '0, AW'(a), '0);
        idle(3);
    endtask

    task automatic sleep_run();
        // R6 R7 R8 R9: traffic across sleep entry and exit, incl. a one-cycle pulse
        for (int i = 0; i < 20; i++) rand_op(4);
        sleep_req = 1;
        for (int i = 0; i < 15; i++) rand_op(4);
        sleep_req = 0;
        for (int i = 0; i < 20; i++) rand_op(4);
        sleep_req = 1;
        rand_op(4);
        sleep_req = 0;
        for (int i = 0; i < 10; i++) rand_op(4);
        sleep_req = 1;
        for (int i = 0; i < 6; i++) tick(1, 1, '1, AW'(i), $urandom());
        sleep_req = 0;
        for (int i = 0; i < 8; i++) rand_op(8);
        idle(3);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) wsched[i] = '0;
        tag = "R11 reset";
        do_reset(1);
        tag = "R1 R3 pipelined back-to-back writes";
        for (int a = 0; a < (1 << AW); a++) tick(1, 1, '1, AW'(a), $urandom());
        tag = "R1 R2 pipelined back-to-back reads";
        readback();
        tag = "R1 R4 R5 pipelined mixed";
        for (int i = 0; i < 300; i++) rand_op(4);
        idle(3);
        tag = "R11 R2 flow-through after reset keeps contents";
        do_reset(0);
        readback();
        tag = "R1 R3 R4 R5 flow-through mixed";
        for (int i = 0; i < 300; i++) rand_op(4);
        idle(3);
        tag = "R6 R7 R8 R9 flow-through sleep";
        sleep_run();
        readback();
        tag = "R6 R7 R8 R9 pipelined sleep";
        do_reset(1);
        sleep_run();
        readback();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule